// File: doc/BRIEF.md
# Load-Immediate and Direct-Load Executor

This block decodes and carries out three load instructions of an 8-bit microcontroller core. They are a constant load into an upper register, a one-word direct load with a compressed 7-bit operand, and a two-word direct load with a full 16-bit data address. It takes 16-bit instruction words from a fetch stage through a valid/take pair. It asks for the second word of the long form and issues reads on a data-space port whose data returns one cycle later. It writes the result into the register file. On the cycle of that write it pulses `done` together with the program-counter advance and the architectural cycle count of the instruction.

The controller has four states. ST_IDLE accepts a first word; an immediate load completes there in the same cycle. IDLE→WB covers the short direct load, which issues its read at once. IDLE→FETCH2 covers the long direct load. FETCH2 holds `ext_req` until the address word arrives. FETCH2→WB issues the read directly. FETCH2→STALL applies when the extra-cycle variant is enabled and the address is inside the internal-SRAM window. STALL→WB issues the delayed read. WB→IDLE writes the returned byte and signals completion.

A parameter decides whether the compressed direct-load pattern is decoded at all, because it collides with other opcodes on larger cores. Any other word is flagged as illegal and leaves the register file untouched. None of these instructions affects the status flags, so the block has no flag output. `cyc_cnt` is the instruction's architectural cycle count, not the time the block is busy.

Top module: `ldx_exec`

## Requirements
- R1: After reset, with no word presented, `rf_we`, `done`, `illegal`, `dm_re` and `ext_req` are all low and `iw_take` is high.
- R2: A valid word matching 1110 KKKK dddd KKKK writes {word[11:8], word[3:0]} to register 16+word[7:4] in the same cycle, with `done`=1, `pc_step`=1, `cyc_cnt`=1.
- R3: A valid word matching 10100 kkk dddd kkkk (short form enabled) raises `dm_re` in the same cycle at the address {~word[8], word[8], word[10], word[9], word[3:0]} with the upper byte zero, so the address always lies in 0x40–0xBF.
- R4: One cycle after a short direct-load read, the returned byte is written to register 16+word[7:4] with `done`=1, `pc_step`=1, `cyc_cnt`=1.
- R5: A valid word matching 1001000 ddddd 0000 raises `ext_req` the following cycle. The next valid word is used as the 16-bit data address. One cycle after the read, the returned byte is written to register word[8:4] with `done`=1, `pc_step`=2, `cyc_cnt`=2.
- R6: While waiting for the address word, `ext_req` stays high and no register write, read or `done` occurs.
- R7: With the extra-cycle variant enabled, an address inside [SRAM_LO, SRAM_HI] delays the read by one cycle and reports `cyc_cnt`=3. An address outside it behaves as in R5.
- R8: Any other valid word in IDLE (including 1001000 ddddd with a non-zero low nibble) pulses `illegal` in that cycle, with no register write, no read, no `done` and `pc_step`=0.
- R9: With the short form disabled, words matching 10100 xxx xxxx xxxx are treated as illegal per R8.
- R10: When `iw_valid` is low in IDLE, no register write, read, `done` or `illegal` occurs, whatever `iw_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iw_valid | input | 1 | Instruction word present |
| iw_data | input | 16 | Instruction word or address word |
| iw_take | output | 1 | Block consumes the presented word this cycle |
| ext_req | output | 1 | Second word of the long direct load is wanted |
| dm_re | output | 1 | Data-space read strobe |
| dm_addr | output | 16 | Data-space read address |
| dm_rdata | input | 8 | Read data, valid the cycle after `dm_re` |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 5 | Destination register index |
| rf_wdata | output | 8 | Value written to the register |
| done | output | 1 | Instruction completes this cycle |
| pc_step | output | 2 | Program-counter advance, valid with `done` |
| cyc_cnt | output | 2 | Architectural cycle count, valid with `done` |
| illegal | output | 1 | Word outside the supported subset |

## Verification
The assertions assume that `dm_rdata` carries the byte addressed by the read of the previous cycle. They also assume the fetch side changes `iw_data` only while `iw_valid` is low or the word is being taken, and that no word arrives while the block sits in STALL or WB. The bench drives words only on cycles where `iw_take` is expected high. It models the data space as a registered lookup computed from the address, and drives inputs on the falling edge and samples a settled time after it. A second instance with the short form disabled and the extra-cycle variant on covers the parameter-selected paths.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int REG_W   = 5;
    localparam int STEP_W  = 2;

    typedef enum logic [1:0] {
        K_NONE,
        K_LDI,
        K_LDS_SHORT,
        K_LDS_LONG
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH2,
        ST_STALL,
        ST_WB
    } state_t;
endpackage

// File: rtl/ldx_decode.sv
module ldx_decode
    import ldx_pkg::*;
#(
    parameter bit SHORT_EN = 1'b1
) (
    input  logic [INSTR_W-1:0] word,
    output op_kind_t           kind,
    output logic [REG_W-1:0]   dest,
    output logic [DATA_W-1:0]  imm,
    output logic [ADDR_W-1:0]  saddr
);
    logic is_ldi;
    logic is_short;
    logic is_long;

    assign is_ldi   = (word[15:12] == 4'b1110);
    assign is_short = SHORT_EN && (word[15:11] == 5'b10100);
    assign is_long  = (word[15:9] == 7'b1001000) && (word[3:0] == 4'b0000);

    assign imm   = {word[11:8], word[3:0]};
    assign saddr = {{(ADDR_W-8){1'b0}}, ~word[8], word[8], word[10], word[9], word[3:0]};

    always_comb begin
        kind = K_NONE;
        dest = {1'b1, word[7:4]};
        if (is_ldi) begin
            kind = K_LDI;
        end else if (is_short) begin
            kind = K_LDS_SHORT;
        end else if (is_long) begin
            kind = K_LDS_LONG;
            dest = word[8:4];
        end
    end
endmodule

// File: rtl/ldx_sram_range.sv
module ldx_sram_range
    import ldx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO = 16'h0100,
    parameter logic [ADDR_W-1:0] HI = 16'hFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/ldx_exec.sv
module ldx_exec
    import ldx_pkg::*;
#(
    parameter bit                SHORT_LDS_EN = 1'b1,
    parameter bit                SRAM_EXTRA   = 1'b0,
    parameter logic [ADDR_W-1:0] SRAM_LO      = 16'h0100,
    parameter logic [ADDR_W-1:0] SRAM_HI      = 16'hFFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iw_valid,
    input  logic [INSTR_W-1:0] iw_data,
    output logic               iw_take,
    output logic               ext_req,
    output logic               dm_re,
    output logic [ADDR_W-1:0]  dm_addr,
    input  logic [DATA_W-1:0]  dm_rdata,
    output logic               rf_we,
    output logic [REG_W-1:0]   rf_addr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               done,
    output logic [STEP_W-1:0]  pc_step,
    output logic [STEP_W-1:0]  cyc_cnt,
    output logic               illegal
);
    state_t              state_q, state_d;
    logic [REG_W-1:0]    dest_q, dest_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [STEP_W-1:0]   pc_q, pc_d;
    logic [STEP_W-1:0]   cyc_q, cyc_d;

    op_kind_t            dec_kind;
    logic [REG_W-1:0]    dec_dest;
    logic [DATA_W-1:0]   dec_imm;
    logic [ADDR_W-1:0]   dec_saddr;
    logic                sram_hit;

    ldx_decode #(.SHORT_EN(SHORT_LDS_EN)) u_decode (
        .word  (iw_data),
        .kind  (dec_kind),
        .dest  (dec_dest),
        .imm   (dec_imm),
        .saddr (dec_saddr)
    );

    generate
        if (SRAM_EXTRA) begin : g_extra
            ldx_sram_range #(.LO(SRAM_LO), .HI(SRAM_HI)) u_range (
                .addr (iw_data),
                .hit  (sram_hit)
            );
        end else begin : g_plain
            assign sram_hit = 1'b0;
        end
    endgenerate

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dest_q  <= '0;
            addr_q  <= '0;
            pc_q    <= '0;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            dest_q  <= dest_d;
            addr_q  <= addr_d;
            pc_q    <= pc_d;
            cyc_q   <= cyc_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        dest_d   = dest_q;
        addr_d   = addr_q;
        pc_d     = pc_q;
        cyc_d    = cyc_q;
        iw_take  = 1'b0;
        ext_req  = 1'b0;
        dm_re    = 1'b0;
        dm_addr  = '0;
        rf_we    = 1'b0;
        rf_addr  = '0;
        rf_wdata = '0;
        done     = 1'b0;
        pc_step  = '0;
        cyc_cnt  = '0;
        illegal  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                iw_take = 1'b1;
                if (iw_valid) begin
                    unique case (dec_kind)
                        K_LDI: begin
                            rf_we    = 1'b1;
                            rf_addr  = dec_dest;
                            rf_wdata = dec_imm;
                            done     = 1'b1;
                            pc_step  = 2'd1;
                            cyc_cnt  = 2'd1;
                        end
                        K_LDS_SHORT: begin
                            dm_re   = 1'b1;
                            dm_addr = dec_saddr;
                            dest_d  = dec_dest;
                            pc_d    = 2'd1;
                            cyc_d   = 2'd1;
                            state_d = ST_WB;
                        end
                        K_LDS_LONG: begin
                            dest_d  = dec_dest;
                            pc_d    = 2'd2;
                            state_d = ST_FETCH2;
                        end
                        default: begin
                            illegal = 1'b1;
                        end
                    endcase
                end
            end
            ST_FETCH2: begin
                iw_take = 1'b1;
                ext_req = 1'b1;
                if (iw_valid) begin
                    addr_d = iw_data;
                    if (sram_hit) begin
                        cyc_d   = 2'd3;
                        state_d = ST_STALL;
                    end else begin
                        dm_re   = 1'b1;
                        dm_addr = iw_data;
                        cyc_d   = 2'd2;
                        state_d = ST_WB;
                    end
                end
            end
            ST_STALL: begin
                dm_re   = 1'b1;
                dm_addr = addr_q;
                state_d = ST_WB;
            end
            ST_WB: begin
                rf_we    = 1'b1;
                rf_addr  = dest_q;
                rf_wdata = dm_rdata;
                done     = 1'b1;
                pc_step  = pc_q;
                cyc_cnt  = cyc_q;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_LDI_UPPER_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && state_q == ST_IDLE) |-> (rf_addr[4] && pc_step == 2'd1)); // R2
    AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_re && state_q == ST_IDLE) |-> (dm_addr >= 16'h0040 && dm_addr <= 16'h00BF)); // R3
    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB) |-> $past(dm_re)); // R4
    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (!rf_we && !done && !illegal)); // R6
    AST_STALL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |=> (done && cyc_cnt == 2'd3)); // R7
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rf_we && !dm_re && $onehot0({done, illegal}))); // R8
endmodule

// File: tb/ldx_exec_bench.sv
`timescale 1ns/100ps
module ldx_exec_bench;
    logic        clk;
    logic        rst_n;
    logic        iv    [2];
    logic [15:0] iw    [2];
    logic        take  [2];
    logic        xreq  [2];
    logic        re    [2];
    logic [15:0] ra    [2];
    logic [7:0]  rd    [2];
    logic        we    [2];
    logic [4:0]  wa    [2];
    logic [7:0]  wd    [2];
    logic        dn    [2];
    logic [1:0]  ps    [2];
    logic [1:0]  cc    [2];
    logic        ill   [2];
    int          n_chk;
    int          n_fail;
    bit          finished;

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    ldx_exec u_ldx_exec (
        .clk(clk), .rst_n(rst_n), .iw_valid(iv[0]), .iw_data(iw[0]),
        .iw_take(take[0]), .ext_req(xreq[0]), .dm_re(re[0]), .dm_addr(ra[0]),
        .dm_rdata(rd[0]), .rf_we(we[0]), .rf_addr(wa[0]), .rf_wdata(wd[0]),
        .done(dn[0]), .pc_step(ps[0]), .cyc_cnt(cc[0]), .illegal(ill[0])
    );

    ldx_exec #(.SHORT_LDS_EN(1'b0), .SRAM_EXTRA(1'b1),
               .SRAM_LO(16'h0100), .SRAM_HI(16'h10FF)) u_ldx_exec_alt (
        .clk(clk), .rst_n(rst_n), .iw_valid(iv[1]), .iw_data(iw[1]),
        .iw_take(take[1]), .ext_req(xreq[1]), .dm_re(re[1]), .dm_addr(ra[1]),
        .dm_rdata(rd[1]), .rf_we(we[1]), .rf_addr(wa[1]), .rf_wdata(wd[1]),
        .done(dn[1]), .pc_step(ps[1]), .cyc_cnt(cc[1]), .illegal(ill[1])
    );

    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always_ff @(posedge clk) begin
        if (re[0]) rd[0] <= memf(ra[0]);
        if (re[1]) rd[1] <= memf(ra[1]);
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset(int s);
        #1;
        chk("R1 quiet", {we[s], dn[s], ill[s], re[s], xreq[s], take[s]}, 6'b000001);
    endtask

    task automatic t_idle(int s);
        iv[s] = 1'b0; iw[s] = 16'hE5A3;
        #1;
        chk("R10 no valid", {we[s], re[s], dn[s], ill[s]}, 4'b0000);
        step();
    endtask

    task automatic t_ldi(int s, logic [3:0] d, logic [7:0] k);
        iv[s] = 1'b1; iw[s] = {4'b1110, k[7:4], d, k[3:0]};
        #1;
        chk("R2 write", {we[s], dn[s], wa[s], wd[s]}, {2'b11, 1'b1, d, k});
        chk("R2 step/cycles", {ps[s], cc[s]}, {2'd1, 2'd1});
        step();
        iv[s] = 1'b0;
    endtask

    task automatic t_short(int s, logic [3:0] d, logic [6:0] k);
        logic [15:0] ea;
        ea = {8'h00, ~k[4], k[4], k[6], k[5], k[3:0]};
        iv[s] = 1'b1; iw[s] = {5'b10100, k[6:4], d, k[3:0]};
        #1;
        chk("R3 read addr", {re[s], ra[s]}, {1'b1, ea});
        step();
        iv[s] = 1'b0;
        #1;
        chk("R4 write", {we[s], dn[s], wa[s], wd[s]}, {2'b11, 1'b1, d, memf(ea)});
        chk("R4 step/cycles", {ps[s], cc[s]}, {2'd1, 2'd1});
        step();
    endtask

    task automatic t_long(int s, logic [4:0] d, logic [15:0] a, int gap, logic [1:0] ecyc);
        iv[s] = 1'b1; iw[s] = {7'b1001000, d, 4'b0000};
        #1;
        chk("R5 first word", {take[s], we[s], re[s], ill[s]}, 4'b1000);
        step();
        iv[s] = 1'b0;
        for (int i = 0; i < gap; i++) begin
            #1;
            chk("R6 waiting", {xreq[s], we[s], re[s], dn[s]}, 4'b1000);
            step();
        end
        iv[s] = 1'b1; iw[s] = a;
        #1;
        chk("R5 second word", {xreq[s], take[s]}, 2'b11);
        if (ecyc == 2'd2) chk("R5 read", {re[s], ra[s]}, {1'b1, a});
        else              chk("R7 read held", {1'b0, re[s]}, 2'b00);
        step();
        iv[s] = 1'b0;
        if (ecyc == 2'd3) begin
            #1;
            chk("R7 delayed read", {re[s], ra[s], we[s]}, {1'b1, a, 1'b0});
            step();
        end
        #1;
        chk("R5 write", {we[s], dn[s], wa[s], wd[s]}, {2'b11, d, memf(a)});
        chk("R7 step/cycles", {ps[s], cc[s]}, {2'd2, ecyc});
        step();
    endtask

    task automatic t_illegal(int s, logic [15:0] w, string req);
        iv[s] = 1'b1; iw[s] = w;
        #1;
        chk(req, {ill[s], we[s], re[s], dn[s], ps[s]}, 6'b100000);
        step();
        iv[s] = 1'b0;
    endtask

    initial begin
        n_chk = 0; n_fail = 0; finished = 1'b0;
        rst_n = 1'b0;
        iv[0] = 1'b0; iv[1] = 1'b0; iw[0] = '0; iw[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset(0);
        t_reset(1);
        step();
        t_idle(0);
        t_ldi(0, 4'h0, 8'h00);
        t_ldi(0, 4'hF, 8'hFF);
        t_ldi(0, 4'hA, 8'h3C);
        t_short(0, 4'h1, 7'h00);
        t_short(0, 4'hE, 7'h7F);
        t_short(0, 4'h7, 7'h15);
        t_long(0, 5'd0, 16'hFF00, 0, 2'd2);
        t_long(0, 5'd31, 16'h0200, 3, 2'd2);
        t_illegal(0, 16'h9004, "R8 low nibble");
        t_illegal(0, 16'h0000, "R8 other op");
        t_ldi(0, 4'h5, 8'h96);
        t_illegal(1, 16'hA3C5, "R9 short off");
        t_ldi(1, 4'h2, 8'h81);
        t_long(1, 5'd9, 16'h0100, 1, 2'd3);
        t_long(1, 5'd20, 16'h10FF, 0, 2'd3);
        t_long(1, 5'd3, 16'h2000, 0, 2'd2);
        t_long(1, 5'd4, 16'h00FF, 0, 2'd2);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule